// File: doc/BRIEF.md
# Burst SPI Register Port

This block is an SPI slave that opens a 32-byte RAM and a small bank of timekeeping and control registers to an external controller. Each transfer, framed by a select line, starts with one command byte. Its most significant bit picks the direction and its low seven bits give the starting location. Any number of data bytes then follow. After each data byte the location advances on its own, so a whole run of registers can be read or written from a single command byte.

The storage lives outside the block, on a simple strobe bus. A write strobe carries the address and data. A read strobe asks for one byte, which the storage returns in the following cycle. SPI inputs are resynchronised into the system clock, which must run several times faster than the serial clock. The block learns the serial clock polarity from the SCK level at the moment the select asserts, so controllers of either polarity work without configuration. The serial data output has a separate enable for the pad driver. When the enable is low the pad is in high impedance.

Top module: `spi_burst_regport`

## Requirements
- R1: The first byte of a transfer is the command. Bit 7 = 1 selects write and bit 7 = 0 selects read. Bits 6..0 are the starting bus address.
- R2: RAM occupies bus addresses 0x00..0x1F (command 0x00..0x1F to read, 0x80..0x9F to write). The clock and control registers occupy 0x20..0x32 (command 0x20..0x32 to read, 0xA0..0xB2 to write), with seconds at 0x20.
- R3: Each further data byte in the same transfer uses the next address, without a new command byte.
- R4: Bits travel MSB first. MOSI is sampled on the trailing SCK edge (the return to idle level). MISO changes on the leading edge.
- R5: The SCK idle level is taken from SCK when select asserts. Both idle-low and idle-high controllers are served.
- R6: `spi_miso_oe` is 1 only while read data bytes are being shifted out. It is 0 during the command byte, during writes and while deselected.
- R7: Dropping select before the eighth bit of a byte ends the transfer. That partial byte causes no bus write.
- R8: Addresses outside both regions read as 0x00 and never produce a bus write or read strobe.
- R9: In the RAM region the address wraps from 0x1F back to 0x00.
- R10: In the register region the address wraps from 0x32 back to 0x20.
- R11: `bus_wr` and `bus_rd` are single-cycle strobes and never coincide. Read data is taken from `bus_rdata` one cycle after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sel | input | 1 | Slave select, active high |
| spi_sck | input | 1 | Serial clock, either polarity |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for the MISO pad |
| bus_wr | output | 1 | Write strobe to storage |
| bus_rd | output | 1 | Read strobe to storage |
| bus_addr | output | 7 | Storage address |
| bus_wdata | output | 8 | Storage write data |
| bus_rdata | input | 8 | Storage read data, valid the cycle after bus_rd |

## Verification
A bad bit counter or a stale phase flag corrupts either a write address or a returned byte within the same transfer. The scoreboard then reports a bad address or data on the very next strobe, or a wrong byte on MISO. A broken wrap rule shows up on the second byte of a burst that crosses a region end, because the strobe goes to the wrong location. A bad output enable is caught at the first bit of the command byte, or at the first bit of read data.

// File: rtl/spireg_pkg.sv
package spireg_pkg;

    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = BYTE_W - 1;
    localparam int BCNT_W  = $clog2(BYTE_W);

    typedef struct packed {
        logic              active;
        logic              cpol;
        logic              addr_ph;
        logic              wr_mode;
        logic              drive;
        logic              sck_prev;
        logic              miso_bit;
        logic [BCNT_W-1:0] bit_cnt;
        logic [BYTE_W-1:0] rx;
        logic [BYTE_W-1:0] tx;
        logic [ADDR_W-1:0] addr;
        logic [1:0]        rd_wait;
        logic              rd_valid;
        logic              bus_wr;
        logic              bus_rd;
        logic [ADDR_W-1:0] bus_addr;
        logic [BYTE_W-1:0] bus_wdata;
    } port_state_t;

endpackage

// File: rtl/spireg_sync.sv
module spireg_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/spireg_addr_map.sv
module spireg_addr_map
    import spireg_pkg::*;
#(
    parameter int RAM_DEPTH = 32,
    parameter int CLK_BASE  = 32,
    parameter int CLK_COUNT = 19
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              valid_o,
    output logic [ADDR_W-1:0] next_o
);

    localparam logic [ADDR_W-1:0] RAM_LAST  = ADDR_W'(RAM_DEPTH - 1);
    localparam logic [ADDR_W-1:0] CLK_FIRST = ADDR_W'(CLK_BASE);
    localparam logic [ADDR_W-1:0] CLK_LAST  = ADDR_W'(CLK_BASE + CLK_COUNT - 1);

    logic in_ram;
    logic in_clk;

    always_comb begin
        in_ram  = (addr_i <= RAM_LAST);
        in_clk  = (addr_i >= CLK_FIRST) && (addr_i <= CLK_LAST);
        valid_o = in_ram || in_clk;
        if (in_ram) begin
            next_o = (addr_i == RAM_LAST) ? '0 : addr_i + 1'b1;
        end else if (in_clk) begin
            next_o = (addr_i == CLK_LAST) ? CLK_FIRST : addr_i + 1'b1;
        end else begin
            next_o = addr_i + 1'b1;
        end
    end

endmodule

// File: rtl/spi_burst_regport.sv
module spi_burst_regport
    import spireg_pkg::*;
#(
    parameter int RAM_DEPTH   = 32,
    parameter int CLK_BASE    = 32,
    parameter int CLK_COUNT   = 19,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sel,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic              bus_wr,
    output logic              bus_rd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [BYTE_W-1:0] bus_wdata,
    input  logic [BYTE_W-1:0] bus_rdata
);

    localparam logic [ADDR_W-1:0] RAM_LAST  = ADDR_W'(RAM_DEPTH - 1);
    localparam logic [ADDR_W-1:0] CLK_FIRST = ADDR_W'(CLK_BASE);
    localparam logic [ADDR_W-1:0] CLK_LAST  = ADDR_W'(CLK_BASE + CLK_COUNT - 1);
    localparam logic [BCNT_W-1:0] LAST_BIT  = BCNT_W'(BYTE_W - 1);

    port_state_t q, d;

    logic sel_s, sck_s, mosi_s;
    logic [2:0] sync_out;

    spireg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({spi_sel, spi_sck, spi_mosi}),
        .q_o   (sync_out)
    );
    assign {sel_s, sck_s, mosi_s} = sync_out;

    // Current address: validity and successor
    logic              cur_valid;
    logic [ADDR_W-1:0] cur_next;

    spireg_addr_map #(.RAM_DEPTH(RAM_DEPTH), .CLK_BASE(CLK_BASE), .CLK_COUNT(CLK_COUNT)) i_cur_map (
        .addr_i  (q.addr),
        .valid_o (cur_valid),
        .next_o  (cur_next)
    );

    // Prefetch target: validity only
    logic              tgt_valid;
    logic [ADDR_W-1:0] tgt_next_unused;
    logic [ADDR_W-1:0] rd_target;
    logic [BYTE_W-1:0] rx_byte;

    spireg_addr_map #(.RAM_DEPTH(RAM_DEPTH), .CLK_BASE(CLK_BASE), .CLK_COUNT(CLK_COUNT)) i_tgt_map (
        .addr_i  (rd_target),
        .valid_o (tgt_valid),
        .next_o  (tgt_next_unused)
    );

    logic sck_edge, lead, trail, byte_done, is_read;

    always_comb begin
        sck_edge  = q.active && (sck_s != q.sck_prev);
        lead      = sck_edge && (sck_s != q.cpol);
        trail     = sck_edge && (sck_s == q.cpol);
        rx_byte   = {q.rx[BYTE_W-2:0], mosi_s};
        byte_done = trail && (q.bit_cnt == LAST_BIT);
        rd_target = q.addr_ph ? rx_byte[ADDR_W-1:0] : cur_next;
        is_read   = q.addr_ph ? !rx_byte[BYTE_W-1] : !q.wr_mode;

        d          = q;
        d.bus_wr   = 1'b0;
        d.bus_rd   = 1'b0;
        d.sck_prev = sck_s;

        // Read return: wait one cycle for storage, then load the shifter
        if (q.rd_wait == 2'd2) begin
            d.rd_wait = 2'd1;
        end else if (q.rd_wait == 2'd1) begin
            d.rd_wait = 2'd0;
            d.tx      = q.rd_valid ? bus_rdata : '0;
        end

        if (!sel_s) begin
            d.active = 1'b0;
            d.drive  = 1'b0;
        end else if (!q.active) begin
            d.active  = 1'b1;
            d.cpol    = sck_s;
            d.addr_ph = 1'b1;
            d.wr_mode = 1'b0;
            d.drive   = 1'b0;
            d.bit_cnt = '0;
            d.rx      = '0;
        end else begin
            if (lead && !q.addr_ph && !q.wr_mode) begin
                d.drive    = 1'b1;
                d.miso_bit = q.tx[BYTE_W-1];
                d.tx       = {q.tx[BYTE_W-2:0], 1'b0};
            end
            if (trail) begin
                d.rx      = rx_byte;
                d.bit_cnt = q.bit_cnt + 1'b1;
                if (byte_done) begin
                    if (q.addr_ph) begin
                        d.addr_ph = 1'b0;
                        d.wr_mode = rx_byte[BYTE_W-1];
                        d.addr    = rx_byte[ADDR_W-1:0];
                    end else begin
                        d.addr = cur_next;
                        if (q.wr_mode && cur_valid) begin
                            d.bus_wr    = 1'b1;
                            d.bus_addr  = q.addr;
                            d.bus_wdata = rx_byte;
                        end
                    end
                    if (is_read) begin
                        d.bus_rd   = tgt_valid;
                        d.bus_addr = rd_target;
                        d.rd_valid = tgt_valid;
                        d.rd_wait  = 2'd2;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign spi_miso_oe = q.active && q.drive;
    assign spi_miso    = spi_miso_oe && q.miso_bit;
    assign bus_wr      = q.bus_wr;
    assign bus_rd      = q.bus_rd;
    assign bus_addr    = q.bus_addr;
    assign bus_wdata   = q.bus_wdata;

    p_oe_read_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        spi_miso_oe |-> (!q.addr_ph && !q.wr_mode))
        else $error("output enabled outside read data");

    p_frame_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.active) |-> (q.addr_ph && q.bit_cnt == '0 && !spi_miso_oe))
        else $error("frame did not start in command phase");

    p_wr_in_region_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> ((bus_addr <= RAM_LAST) || (bus_addr >= CLK_FIRST && bus_addr <= CLK_LAST)))
        else $error("write strobe to unmapped address");

    p_wr_after_command_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> $past(q.active && !q.addr_ph && q.wr_mode))
        else $error("write strobe outside a write data phase");

    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd))
        else $error("read and write strobes together");

    p_rd_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> !bus_rd)
        else $error("read strobe longer than one cycle");

endmodule

// File: tb/test_spi_burst_regport.sv
module test_spi_burst_regport;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sel = 1'b0;
    logic       spi_sck = 1'b0;
    logic       spi_mosi = 1'b0;
    logic       spi_miso, spi_miso_oe;
    logic       bus_wr, bus_rd;
    logic [6:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata = 8'h00;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    spi_burst_regport i_spi_burst_regport (
        .clk(clk), .rst_n(rst_n),
        .spi_sel(spi_sel), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // Storage model with one-cycle read latency
    logic [7:0] mem [128];
    logic [7:0] shadow [128];
    initial for (int i = 0; i < 128; i++) begin mem[i] = 8'h00; shadow[i] = 8'h00; end

    always @(posedge clk) begin
        if (bus_wr) mem[bus_addr] <= bus_wdata;
        if (bus_rd) bus_rdata <= mem[bus_addr];
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_valid(input logic [6:0] a);
        return (a <= 7'h1F) || (a >= 7'h20 && a <= 7'h32);
    endfunction

    function automatic logic [6:0] exp_next(input logic [6:0] a);
        if (a <= 7'h1F) return (a == 7'h1F) ? 7'h00 : a + 7'd1;
        if (a >= 7'h20 && a <= 7'h32) return (a == 7'h32) ? 7'h20 : a + 7'd1;
        return a + 7'd1;
    endfunction

    // Scoreboard of expected write strobes {addr, data}
    logic [14:0] exp_wr [$];

    always @(negedge clk) begin
        if (rst_n && bus_wr) begin
            if (exp_wr.size() == 0) begin
                chk(1'b0, "R8 unexpected write", {bus_addr, bus_wdata}, 0);
            end else begin
                logic [14:0] e;
                e = exp_wr.pop_front();
                chk({bus_addr, bus_wdata} == e, "R3 write strobe", {bus_addr, bus_wdata}, e);
            end
        end
    end

    logic [7:0] txb [$];
    logic [7:0] rxb [$];
    bit oe_cmd_bad, oe_data_bad;

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic cp, input int nbits, input bit rd);
        logic [7:0] acc;
        rxb.delete();
        oe_cmd_bad = 0;
        oe_data_bad = 0;
        acc = 8'h00;
        spi_sck = cp;
        wclk(6);
        spi_sel = 1'b1;
        wclk(10);
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = txb[i / 8][7 - (i % 8)];
            spi_sck = ~cp;
            wclk(10);
            if (i < 8) begin
                if (spi_miso_oe) oe_cmd_bad = 1;
            end else begin
                if (spi_miso_oe != rd) oe_data_bad = 1;
            end
            acc = {acc[6:0], spi_miso};
            spi_sck = cp;
            wclk(10);
            if ((i % 8) == 7 && i >= 8) rxb.push_back(acc);
        end
        wclk(4);
        spi_sel = 1'b0;
        wclk(12);
    endtask

    task automatic spi_write(input logic cp, input logic [6:0] a0, input logic [7:0] data [$], input string req);
        logic [6:0] a;
        a = a0;
        txb.delete();
        txb.push_back({1'b1, a0});
        foreach (data[k]) begin
            txb.push_back(data[k]);
            if (exp_valid(a)) begin
                exp_wr.push_back({a, data[k]});
                shadow[a] = data[k];
            end
            a = exp_next(a);
        end
        xfer(cp, 8 * txb.size(), 1'b0);
        chk(exp_wr.size() == 0, {req, " all writes seen"}, exp_wr.size(), 0);
        chk(!oe_cmd_bad && !oe_data_bad, "R6 oe low during write", spi_miso_oe, 0);
    endtask

    task automatic spi_read(input logic cp, input logic [6:0] a0, input int n, input string req);
        logic [6:0] a;
        logic [7:0] e;
        a = a0;
        txb.delete();
        txb.push_back({1'b0, a0});
        for (int k = 0; k < n; k++) txb.push_back(8'h5A);
        xfer(cp, 8 * (n + 1), 1'b1);
        chk(!oe_cmd_bad, "R6 oe low in command", 1, 0);
        chk(!oe_data_bad, "R6 oe high in read data", 0, 1);
        for (int k = 0; k < n; k++) begin
            e = exp_valid(a) ? shadow[a] : 8'h00;
            chk(rxb[k] == e, req, rxb[k], e);
            a = exp_next(a);
        end
        chk(spi_miso_oe == 1'b0, "R6 oe low after deselect", spi_miso_oe, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : driver
        wclk(5);
        rst_n = 1'b1;
        wclk(5);
        chk(spi_miso_oe == 1'b0, "R6 reset oe", spi_miso_oe, 0);
        chk(bus_wr == 1'b0, "R11 reset wr", bus_wr, 0);
        chk(bus_rd == 1'b0, "R11 reset rd", bus_rd, 0);

        // R1 R2 R3 R4: burst write into RAM, idle-low clock
        spi_write(1'b0, 7'h05, '{8'hA1, 8'hB2, 8'hC3}, "R1 R2 R3");
        // R5: read back with idle-high clock, then idle-low
        spi_read(1'b1, 7'h05, 3, "R5 R4 read idle-high");
        spi_read(1'b0, 7'h06, 2, "R4 R11 read idle-low");

        // R9: RAM wrap
        spi_write(1'b1, 7'h1E, '{8'h11, 8'h22, 8'h33}, "R9");
        spi_read(1'b0, 7'h1F, 2, "R9 read wrap");

        // R10: register region wrap
        spi_write(1'b0, 7'h31, '{8'h44, 8'h55, 8'h66}, "R10");
        spi_read(1'b1, 7'h32, 2, "R10 read wrap");
        spi_read(1'b0, 7'h20, 1, "R2 seconds");

        // R8: unmapped addresses
        spi_write(1'b0, 7'h40, '{8'h7E, 8'h7F}, "R8");
        chk(mem[7'h40] == 8'h00, "R8 gap untouched", mem[7'h40], 0);
        spi_read(1'b1, 7'h40, 2, "R8 gap reads zero");
        spi_read(1'b0, 7'h32, 2, "R8 R10 mixed");

        // R7: select drops after four data bits
        txb.delete();
        txb.push_back(8'h85);
        txb.push_back(8'hEE);
        xfer(1'b0, 12, 1'b0);
        wclk(10);
        chk(exp_wr.size() == 0, "R7 no pending", exp_wr.size(), 0);
        spi_read(1'b0, 7'h05, 1, "R7 partial byte discarded");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule